// File: doc/BRIEF.md
# Two-Tier Rotating Bus Arbiter

This block decides which of four masters owns a shared parallel bus. Each master raises its own request line and receives its own grant line. The masters form two groups. The fast group rotates among its members in turn. After each complete pass of the fast group, one slow-group member gets a single turn, and the slow members take those turns in round-robin order. With fast masters A and B and slow masters X and Y, a fully loaded bus is granted A B X A B Y A B X.

The arbiter watches the active-low frame and initiator-ready signals, so it can move the grant to the next master while a transfer is still running. The new owner waits until it sees the bus idle before it starts. When another master asks for the bus, the arbiter takes the grant away from the current owner, and the owner finishes under its own latency timer. When nobody is asking, the bus is parked. A mode input selects whether it stays with the last owner or goes to one fixed master.

Top module: `two_tier_arb`

## Requirements
- R1: There is one request input bit and one grant output bit per master. Master i uses bit i. At most one grant bit is high in any clock.
- R2: Masters 0 and 1 form the fast group and masters 2 and 3 the slow group. With all four requesting on a busy bus, successive grants run 0,1,2,0,1,3,0,1,2.
- R3: A master that is not requesting is skipped in its turn, and the grant goes to the next eligible master in the same clock. A tier's pointer moves only when that tier issues a grant to a requester. A slow turn that finds no slow requester lapses, and the fast grant made in its place starts a new fast pass.
- R4: While the bus is busy (frame_n_i low or irdy_n_i low), a grant that must change moves from the old owner to the new owner at a single clock edge.
- R5: While the bus is idle (frame_n_i and irdy_n_i both high), a grant that must change is first dropped for exactly one clock, and then given to the new owner.
- R6: When a master other than the owner requests, the owner loses its grant at the next edge.
- R7: With park_last_i low and no request pending, the grant goes to master PARK_ID (default 0), even though that master is not requesting.
- R8: With park_last_i high and no request pending, the grant stays with the last master that won by requesting. After reset that master is PARK_ID.
- R9: Reset is synchronous and active high. It clears all grants whatever the requests are. The first grant appears only at the first edge at which rst is low.
- R10: An owner that is the only requester keeps its grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | N_MASTERS | Request per master, bit i = master i |
| frame_n_i | input | 1 | Bus frame signal, active low |
| irdy_n_i | input | 1 | Initiator-ready signal, active low |
| park_last_i | input | 1 | 1 = park on last owner, 0 = park on PARK_ID |
| gnt_o | output | N_MASTERS | Registered grant per master, bit i = master i |

## Verification
The bench runs the full nine-grant two-tier sequence. An arbiter that treats all four masters as one flat ring would produce 0,1,2,3 instead. It then runs skipped turns and a lapsed slow slot, where a design that advances its pointers on every decision, rather than on every issued grant, falls out of step. It also compares the single-edge handover on a busy bus with the one-clock gap on an idle bus. A missing gap would show two consecutive owners with no idle clock between them, and a gap added on a busy bus would cost an extra clock. Parking is driven in both modes, with the bus both busy and idle, and again straight after reset, where a design that grants during reset or parks the wrong master gives a visibly wrong grant vector.

// File: rtl/two_tier_arb_pkg.sv
package two_tier_arb_pkg;
  // Index width that never collapses to zero bits.
  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/two_tier_arb_rr_pick.sv
module two_tier_arb_rr_pick
  import two_tier_arb_pkg::*;
#(
  parameter int W  = 2,
  localparam int PW = idx_width(W)
) (
  input  logic [W-1:0]  req,
  input  logic [PW-1:0] ptr,
  output logic          found,
  output logic [PW-1:0] idx
);
  // First requester at or after ptr, wrapping round the group.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int off = 0; off < W; off++) begin
      int cand;
      cand = (int'(ptr) + off) % W;
      if (!found && req[cand]) begin
        found = 1'b1;
        idx   = PW'(cand);
      end
    end
  end
endmodule

// File: rtl/two_tier_arb_sched.sv
module two_tier_arb_sched
  import two_tier_arb_pkg::*;
#(
  parameter int N_MASTERS = 4,
  parameter int N_FAST    = 2,
  localparam int N_SLOW   = N_MASTERS - N_FAST,
  localparam int IW       = idx_width(N_MASTERS),
  localparam int FPW      = idx_width(N_FAST),
  localparam int SPW      = idx_width(N_SLOW),
  localparam int CW       = $clog2(N_FAST + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N_MASTERS-1:0] elig_i,
  input  logic                 adv_i,
  output logic                 win_valid_o,
  output logic [IW-1:0]        win_id_o
);
  logic [FPW-1:0] fptr_q;
  logic [SPW-1:0] sptr_q;
  logic [CW-1:0]  fcnt_q;
  logic           f_found, s_found, pick_slow, slow_due;
  logic [FPW-1:0] f_idx;
  logic [SPW-1:0] s_idx;

  two_tier_arb_rr_pick #(.W(N_FAST)) u_fast (
    .req(elig_i[N_FAST-1:0]), .ptr(fptr_q), .found(f_found), .idx(f_idx));

  two_tier_arb_rr_pick #(.W(N_SLOW)) u_slow (
    .req(elig_i[N_MASTERS-1:N_FAST]), .ptr(sptr_q), .found(s_found), .idx(s_idx));

  // A full fast pass has been issued: the next slot belongs to the slow tier.
  assign slow_due = (fcnt_q >= CW'(N_FAST));

  always_comb begin
    if (slow_due) pick_slow = s_found;
    else          pick_slow = !f_found && s_found;
  end

  assign win_valid_o = f_found || s_found;
  assign win_id_o    = pick_slow ? (IW'(N_FAST) + IW'(s_idx)) : IW'(f_idx);

  always_ff @(posedge clk) begin
    if (rst) begin
      fptr_q <= '0;
      sptr_q <= '0;
      fcnt_q <= '0;
    end else if (adv_i && win_valid_o) begin
      if (pick_slow) begin
        sptr_q <= (int'(s_idx) == N_SLOW - 1) ? '0 : s_idx + 1'b1;
        fcnt_q <= '0;
      end else begin
        fptr_q <= (int'(f_idx) == N_FAST - 1) ? '0 : f_idx + 1'b1;
        fcnt_q <= slow_due ? CW'(1) : fcnt_q + 1'b1;
      end
    end
  end

  AST_PASS_BOUND: assert property (@(posedge clk) disable iff (rst)
    fcnt_q <= CW'(N_FAST)); // R2

  AST_SLOW_RESETS_PASS: assert property (@(posedge clk) disable iff (rst)
    (adv_i && win_valid_o && int'(win_id_o) >= N_FAST) |=> fcnt_q == '0); // R2
endmodule

// File: rtl/two_tier_arb.sv
module two_tier_arb
  import two_tier_arb_pkg::*;
#(
  parameter int N_MASTERS = 4,
  parameter int N_FAST    = 2,
  parameter int PARK_ID   = 0,
  localparam int IW       = idx_width(N_MASTERS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N_MASTERS-1:0] req_i,
  input  logic                 frame_n_i,
  input  logic                 irdy_n_i,
  input  logic                 park_last_i,
  output logic [N_MASTERS-1:0] gnt_o
);
  localparam logic [N_MASTERS-1:0] FIXED_VEC = N_MASTERS'(1) << PARK_ID;

  logic [N_MASTERS-1:0] gnt_q, gnt_d, elig, win_vec, park_vec;
  logic [IW-1:0]        last_q, last_d, win_id;
  logic                 owner_v, bus_idle, win_valid, move_req, adv;

  assign owner_v  = |gnt_q;
  assign bus_idle = frame_n_i && irdy_n_i;
  // While someone holds the grant only the others compete for it.
  assign elig     = owner_v ? (req_i & ~gnt_q) : req_i;

  two_tier_arb_sched #(.N_MASTERS(N_MASTERS), .N_FAST(N_FAST)) u_sched (
    .clk(clk), .rst(rst), .elig_i(elig), .adv_i(adv),
    .win_valid_o(win_valid), .win_id_o(win_id));

  assign win_vec  = N_MASTERS'(1) << win_id;
  assign park_vec = park_last_i ? (N_MASTERS'(1) << last_q) : FIXED_VEC;
  assign move_req = win_valid ||
                    (!(|req_i) && !park_last_i && (gnt_q != FIXED_VEC));

  always_comb begin
    gnt_d  = gnt_q;
    last_d = last_q;
    adv    = 1'b0;
    if (!owner_v) begin
      if (win_valid) begin
        gnt_d  = win_vec;
        last_d = win_id;
        adv    = 1'b1;
      end else begin
        gnt_d = park_vec;
      end
    end else if (move_req) begin
      if (bus_idle) begin
        gnt_d = '0;               // one dead clock before handover
      end else if (win_valid) begin
        gnt_d  = win_vec;         // hidden handover during a transfer
        last_d = win_id;
        adv    = 1'b1;
      end else begin
        gnt_d = FIXED_VEC;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt_q  <= '0;
      last_q <= IW'(PARK_ID);
    end else begin
      gnt_q  <= gnt_d;
      last_q <= last_d;
    end
  end

  assign gnt_o = gnt_q;

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt_q)); // R1

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> gnt_q == '0); // R9

  AST_IDLE_GAP: assert property (@(posedge clk) disable iff (rst)
    (bus_idle && owner_v) |=> (gnt_q == $past(gnt_q) || gnt_q == '0)); // R5

  AST_BUSY_HANDOVER: assert property (@(posedge clk) disable iff (rst)
    (!bus_idle && owner_v && ((req_i & ~gnt_q) != '0))
      |=> (gnt_q != $past(gnt_q) && gnt_q != '0)); // R4

  AST_SOLE_OWNER_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (owner_v && ((req_i & gnt_q) != '0) && ((req_i & ~gnt_q) == '0))
      |=> $stable(gnt_q)); // R10

  AST_FIXED_PARK: assert property (@(posedge clk) disable iff (rst)
    (!owner_v && req_i == '0 && !park_last_i) |=> gnt_q == FIXED_VEC); // R7
endmodule

// File: tb/two_tier_arb_tb_top.sv
`timescale 1ns/1ps
module two_tier_arb_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] req = '0;
  logic       frame_n = 1'b1, irdy_n = 1'b1, park_last = 1'b0;
  logic [3:0] gnt;
  int         errors = 0, checks = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  two_tier_arb dut_i (
    .clk(clk), .rst(rst), .req_i(req), .frame_n_i(frame_n),
    .irdy_n_i(irdy_n), .park_last_i(park_last), .gnt_o(gnt));

  // {tag, req, frame_n, irdy_n, park_last, expected grant after the edge}
  localparam int NV = 26;
  localparam logic [14:0] VECS [NV] = '{
    {4'd2, 4'b1111, 1'b0, 1'b1, 1'b0, 4'b0001}, // R2 master 0
    {4'd2, 4'b1111, 1'b0, 1'b1, 1'b0, 4'b0010}, // R2 master 1
    {4'd2, 4'b1111, 1'b0, 1'b1, 1'b0, 4'b0100}, // R2 slow 2
    {4'd2, 4'b1111, 1'b0, 1'b1, 1'b0, 4'b0001},
    {4'd2, 4'b1111, 1'b0, 1'b1, 1'b0, 4'b0010},
    {4'd2, 4'b1111, 1'b0, 1'b1, 1'b0, 4'b1000}, // R2 slow 3
    {4'd2, 4'b1111, 1'b0, 1'b1, 1'b0, 4'b0001},
    {4'd2, 4'b1111, 1'b0, 1'b1, 1'b0, 4'b0010},
    {4'd2, 4'b1111, 1'b0, 1'b1, 1'b0, 4'b0100}, // R2 back to slow 2
    {4'd5, 4'b0001, 1'b1, 1'b1, 1'b0, 4'b0000}, // R5 idle gap
    {4'd5, 4'b0001, 1'b1, 1'b1, 1'b0, 4'b0001}, // R5 then grant
    {4'd3, 4'b0101, 1'b0, 1'b0, 1'b0, 4'b0100}, // R3 skip 1 and 3
    {4'd4, 4'b0011, 1'b0, 1'b1, 1'b0, 4'b0010}, // R4 direct move
    {4'd10,4'b0010, 1'b0, 1'b1, 1'b0, 4'b0010}, // R10 sole owner busy
    {4'd10,4'b0010, 1'b1, 1'b1, 1'b0, 4'b0010}, // R10 sole owner idle
    {4'd7, 4'b0000, 1'b1, 1'b1, 1'b0, 4'b0000}, // R7 gap before park
    {4'd7, 4'b0000, 1'b1, 1'b1, 1'b0, 4'b0001}, // R7 parked on 0
    {4'd7, 4'b0000, 1'b1, 1'b1, 1'b0, 4'b0001}, // R7 stays parked
    {4'd6, 4'b1000, 1'b0, 1'b1, 1'b1, 4'b1000}, // R6 preempt parked
    {4'd8, 4'b0000, 1'b1, 1'b1, 1'b1, 4'b1000}, // R8 last owner keeps
    {4'd7, 4'b0000, 1'b0, 1'b1, 1'b0, 4'b0001}, // R7 busy move to park
    {4'd6, 4'b0011, 1'b0, 1'b1, 1'b0, 4'b0010}, // R6 preempt to 1
    {4'd3, 4'b0011, 1'b0, 1'b1, 1'b0, 4'b0001}, // R3 pass complete
    {4'd3, 4'b0011, 1'b0, 1'b1, 1'b0, 4'b0010}, // R3 slow slot lapses
    {4'd3, 4'b1011, 1'b0, 1'b1, 1'b0, 4'b0001}, // R3 new pass second
    {4'd2, 4'b1011, 1'b0, 1'b1, 1'b0, 4'b1000}  // R2 slow turn to 3
  };

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: gnt=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic check_onehot();
    checks++;
    if ($countones(gnt) > 1) begin
      errors++;
      $display("FAIL R1: gnt=%b expected at most one bit", gnt);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R9 grant held low in reset", gnt, 4'b0000);
    rst = 1'b0;
    req = 4'b1111;
    frame_n = 1'b0;
    #0.5;
    check("R9 no grant before first edge", gnt, 4'b0000);
    for (int i = 0; i < NV; i++) begin
      logic [14:0] v;
      v = VECS[i];
      req       = v[10:7];
      frame_n   = v[6];
      irdy_n    = v[5];
      park_last = v[4];
      @(posedge clk);
      #1;
      check($sformatf("R%0d row %0d", v[14:11], i), gnt, v[3:0]);
      check_onehot();
    end
    // Reset with requests pending still clears grants.
    rst = 1'b1;
    req = 4'b1111;
    @(posedge clk);
    #1;
    check("R9 sync reset clears", gnt, 4'b0000);
    // After reset the last-owner park target is master 0.
    rst = 1'b0;
    req = 4'b0000;
    frame_n = 1'b1;
    irdy_n = 1'b1;
    park_last = 1'b1;
    @(posedge clk);
    #1;
    check("R8 park after reset", gnt, 4'b0001);
    // Lone request after reset takes the idle gap.
    req = 4'b0100;
    @(posedge clk);
    #1;
    check("R5 gap from parked owner", gnt, 4'b0000);
    @(posedge clk);
    #1;
    check("R5 slow master after gap", gnt, 4'b0100);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule